// File: doc/BRIEF.md
# Serial-loaded streaming address counter

This block keeps the running bit address for a sequential voice store built from DRAM parts that are one bit wide. A controller sends a start address one bit at a time on a serial data pin. Each rising edge of a shift clock moves one bit into a holding register. A rising edge of a separate transfer strobe then copies that register into the running counter. After that, every falling edge of the read/write clock advances the counter by one bit position.

The counter value is split into a row address, a column address and a one-hot device select. These feed a DRAM sequencer that sits outside this block. How the address is split depends on a two-bit population mode, which says which mix of 1, 4 or 16 Mbit parts is fitted. The counter wraps to zero after the last address of the fitted population.

All three strobes are sampled on the system clock and edge-detected there. A change on a strobe appears at the outputs after the next rising system clock edge.

Top module: `stream_addr_ctr`

## Requirements
- R1: Each rising edge of `shift_clk` shifts `ser_data` into the 25-bit holding register at the least significant end. A start address is therefore sent most significant bit first, and only the last 25 bits sent are kept.
- R2: Shifting, and idle cycles with no strobe edge, leave `bit_addr` unchanged.
- R3: A rising edge of `xfer_stb` loads the holding register into `bit_addr`. When a shift edge falls in the same cycle, the value loaded is the register as it was before that shift. When a read/write falling edge falls in the same cycle, the load wins and no increment happens.
- R4: Each falling edge of `rw_clk` adds one to `bit_addr`.
- R5: The last address depends on the mode: 2^23-1 for mode 0, 2^25-1 for modes 1 and 3, and 7*2^20-1 for mode 2. A step taken from an address at or above the last address gives zero.
- R6: Mode 0 (`mode`=00, up to eight 1 Mbit parts) works as follows. `col_addr` is address bits 9..0 and `row_addr` is bits 19..10. The device index is bits 22..20. The upper address lines are zero.
- R7: Mode 1 (`mode`=01, up to eight 4 Mbit parts) works as follows. `col_addr` is bits 10..0 and `row_addr` is bits 21..11. The device index is bits 24..22.
- R8: Mode 2 (`mode`=10) has one 4 Mbit part and up to three 1 Mbit parts. Addresses below 2^22 go to device 0 with the 11/11 split of R7. Above that, the offset from 2^22 is used: each 2^20 range of the offset selects devices 1, 2 and 3 in turn, with the 10/10 split of R6.
- R9: Mode 3 (`mode`=11, one or two 16 Mbit parts) works as follows. `col_addr` is bits 11..0 and `row_addr` is bits 23..12. The device index is bit 24, so only `dev_sel` bits 0 and 1 can be set.
- R10: `dev_sel` always has exactly one bit set. Bit i is set when device i is selected.
- R11: While `rst_n` is low at a rising `clk` edge, both the holding register and the counter clear. A transfer made straight after reset, with no shifting in between, loads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | DRAM population mode |
| ser_data | input | 1 | Serial start address bit |
| shift_clk | input | 1 | Shift clock; a rising edge takes one serial bit |
| xfer_stb | input | 1 | Transfer strobe; a rising edge loads the counter |
| rw_clk | input | 1 | Read/write clock; a falling edge advances the counter |
| bit_addr | output | 25 | Current bit address |
| row_addr | output | 12 | Row part of the current address |
| col_addr | output | 12 | Column part of the current address |
| dev_sel | output | 8 | One-hot device select |

## Verification
The bench builds the block with its default of twelve multiplexed address lines. This gives the full 25-bit counter, eight device selects and the real boundaries of every mode. The corners of interest lie millions of steps apart, and the serial load reaches them directly. The bench loads addresses two or three steps before each device boundary, the large-to-small part crossing in mode 2 and each mode's wrap point, then steps across them. It also drives shift-with-transfer and transfer-with-step in the same cycle, and checks the transfer that follows a reset taken in the middle of a run.

// File: rtl/sac_pkg.sv
package sac_pkg;
    typedef enum logic [1:0] {
        POP_SMALL = 2'b00,
        POP_MID   = 2'b01,
        POP_MIXED = 2'b10,
        POP_LARGE = 2'b11
    } pop_mode_e;

    localparam int NUM_DEV = 8;
    localparam int DEV_IDX_W = $clog2(NUM_DEV);
endpackage

// File: rtl/sac_edge_det.sv
module sac_edge_det #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);
    localparam logic IDLE_LVL = FALLING ? 1'b1 : 1'b0;
    localparam logic RST_PREV = FALLING ? 1'b0 : 1'b1;

    logic prev_d, prev_q;

    always_comb begin
        prev_d = rst_n ? sig : RST_PREV;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = prev_q & ~sig & (IDLE_LVL == 1'b1);
        end else begin : g_rise
            assign pulse = ~prev_q & sig & (IDLE_LVL == 1'b0);
        end
    endgenerate
endmodule

// File: rtl/sac_addr_split.sv
module sac_addr_split
    import sac_pkg::*;
#(
    parameter int LINES = 12,
    localparam int AW = 2 * LINES + 1
) (
    input  logic [AW-1:0]      addr,
    input  logic [1:0]         mode,
    output logic [LINES-1:0]   row_addr,
    output logic [LINES-1:0]   col_addr,
    output logic [NUM_DEV-1:0] dev_sel,
    output logic [AW-1:0]      last_addr
);
    localparam int HALF_S = LINES - 2;
    localparam int HALF_M = LINES - 1;
    localparam int HALF_L = LINES;
    localparam longint unsigned SIZE_S = 64'd1 << (2 * HALF_S);
    localparam longint unsigned SIZE_M = 64'd1 << (2 * HALF_M);
    localparam longint unsigned SIZE_L = 64'd1 << (2 * HALF_L);

    pop_mode_e             pm;
    longint unsigned       a_w;
    longint unsigned       rel;
    longint unsigned       last_w;
    longint unsigned       dev_w;
    int                    half;
    logic [DEV_IDX_W-1:0]  dev_idx;

    always_comb begin
        pm   = pop_mode_e'(mode);
        a_w  = 64'(addr);
        rel  = a_w;
        half = HALF_S;
        dev_w = 64'd0;
        last_w = SIZE_S * NUM_DEV - 1;
        case (pm)
            POP_SMALL: begin
                half  = HALF_S;
                dev_w = a_w >> (2 * HALF_S);
                last_w = SIZE_S * NUM_DEV - 1;
            end
            POP_MID: begin
                half  = HALF_M;
                dev_w = a_w >> (2 * HALF_M);
                last_w = SIZE_M * NUM_DEV - 1;
            end
            POP_MIXED: begin
                last_w = SIZE_M + 3 * SIZE_S - 1;
                if (a_w < SIZE_M) begin
                    half  = HALF_M;
                    dev_w = 64'd0;
                end else begin
                    rel   = a_w - SIZE_M;
                    half  = HALF_S;
                    dev_w = 64'd1 + (rel >> (2 * HALF_S));
                end
            end
            default: begin
                half  = HALF_L;
                dev_w = a_w >> (2 * HALF_L);
                last_w = SIZE_L * 2 - 1;
            end
        endcase
        col_addr  = LINES'(rel & ((64'd1 << half) - 64'd1));
        row_addr  = LINES'((rel >> half) & ((64'd1 << half) - 64'd1));
        dev_idx   = DEV_IDX_W'(dev_w);
        dev_sel   = NUM_DEV'(1) << dev_idx;
        last_addr = AW'(last_w);
    end
endmodule

// File: rtl/stream_addr_ctr.sv
module stream_addr_ctr
    import sac_pkg::*;
#(
    parameter int LINES = 12,
    localparam int AW = 2 * LINES + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic               ser_data,
    input  logic               shift_clk,
    input  logic               xfer_stb,
    input  logic               rw_clk,
    output logic [AW-1:0]      bit_addr,
    output logic [LINES-1:0]   row_addr,
    output logic [LINES-1:0]   col_addr,
    output logic [NUM_DEV-1:0] dev_sel
);
    typedef struct packed {
        logic [AW-1:0] sreg;
        logic [AW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t    st_d, st_q;
    logic          shift_p, xfer_p, step_p;
    logic [AW-1:0] last_addr;

    sac_edge_det #(.FALLING(1'b0)) u_shift_edge (
        .clk(clk), .rst_n(rst_n), .sig(shift_clk), .pulse(shift_p)
    );
    sac_edge_det #(.FALLING(1'b0)) u_xfer_edge (
        .clk(clk), .rst_n(rst_n), .sig(xfer_stb), .pulse(xfer_p)
    );
    sac_edge_det #(.FALLING(1'b1)) u_step_edge (
        .clk(clk), .rst_n(rst_n), .sig(rw_clk), .pulse(step_p)
    );

    sac_addr_split #(.LINES(LINES)) u_split (
        .addr(st_q.cnt),
        .mode(mode),
        .row_addr(row_addr),
        .col_addr(col_addr),
        .dev_sel(dev_sel),
        .last_addr(last_addr)
    );

    always_comb begin
        st_d = st_q;
        if (shift_p) begin
            st_d.sreg = {st_q.sreg[AW-2:0], ser_data};
        end
        if (xfer_p) begin
            st_d.cnt = st_q.sreg;
        end else if (step_p) begin
            st_d.cnt = (st_q.cnt >= last_addr) ? '0 : st_q.cnt + AW'(1);
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bit_addr = st_q.cnt;
endmodule

// File: rtl/sac_checker.sv
module sac_checker
    import sac_pkg::*;
#(
    parameter int LINES = 12,
    localparam int AW = 2 * LINES + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode,
    input logic               shift_p,
    input logic               xfer_p,
    input logic               step_p,
    input logic [AW-1:0]      last_addr,
    input logic [AW-1:0]      bit_addr,
    input logic [NUM_DEV-1:0] dev_sel
);
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> bit_addr == '0);

    assert_shift_no_disturb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_p && !step_p) |=> $stable(bit_addr));

    assert_step_or_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_p && !xfer_p) |=>
            bit_addr == (($past(bit_addr) >= $past(last_addr)) ? AW'(0)
                                                               : $past(bit_addr) + AW'(1)));

    assert_one_device_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dev_sel) == 1);

    assert_large_two_parts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b11 |-> dev_sel[NUM_DEV-1:2] == '0);
endmodule

bind stream_addr_ctr sac_checker #(.LINES(LINES)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .mode(mode),
    .shift_p(shift_p),
    .xfer_p(xfer_p),
    .step_p(step_p),
    .last_addr(last_addr),
    .bit_addr(bit_addr),
    .dev_sel(dev_sel)
);

// File: tb/stream_addr_ctr_tb.sv
module stream_addr_ctr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        ser_data = 1'b0;
    logic        shift_clk = 1'b0;
    logic        xfer_stb = 1'b0;
    logic        rw_clk = 1'b1;
    logic [24:0] bit_addr;
    logic [11:0] row_addr;
    logic [11:0] col_addr;
    logic [7:0]  dev_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m_sreg = 0;
    longint m_cnt = 0;
    bit p_sh = 1'b1, p_xf = 1'b1, p_rw = 1'b0;

    always #2 clk = ~clk;

    stream_addr_ctr u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ser_data(ser_data),
        .shift_clk(shift_clk), .xfer_stb(xfer_stb), .rw_clk(rw_clk),
        .bit_addr(bit_addr), .row_addr(row_addr), .col_addr(col_addr),
        .dev_sel(dev_sel)
    );

    function automatic longint last_of(int md);
        case (md)
            0: return 64'd8388607;
            2: return 64'd7340031;
            default: return 64'd33554431;
        endcase
    endfunction

    task automatic expect_split(input longint a, input int md,
                                output longint row, output longint col, output longint dev);
        longint mb = 1048576;
        longint off;
        case (md)
            0: begin dev = (a / mb) % 8; off = a % mb; row = off / 1024; col = off % 1024; end
            1: begin dev = (a / (4*mb)) % 8; off = a % (4*mb); row = off / 2048; col = off % 2048; end
            2: begin
                if (a < 4*mb) begin dev = 0; row = a / 2048; col = a % 2048; end
                else begin
                    off = a - 4*mb;
                    dev = (1 + off / mb) % 8; off = off % mb;
                    row = off / 1024; col = off % 1024;
                end
            end
            default: begin dev = (a / (16*mb)) % 8; off = a % (16*mb); row = off / 4096; col = off % 4096; end
        endcase
    endtask

    task automatic tick(input bit sd, input bit sh, input bit xf, input bit rw, input string req);
        longint er, ec, ed;
        bit sp, xp, rp;
        @(negedge clk);
        ser_data = sd; shift_clk = sh; xfer_stb = xf; rw_clk = rw;
        if (!rst_n) begin
            m_sreg = 0; m_cnt = 0; p_sh = 1'b1; p_xf = 1'b1; p_rw = 1'b0;
        end else begin
            sp = sh && !p_sh; xp = xf && !p_xf; rp = !rw && p_rw;
            p_sh = sh; p_xf = xf; p_rw = rw;
            if (xp) m_cnt = m_sreg;
            else if (rp) m_cnt = (m_cnt >= last_of(int'(mode))) ? 0 : m_cnt + 1;
            if (sp) m_sreg = ((m_sreg << 1) | longint'(sd)) & 64'h1FFFFFF;
        end
        @(posedge clk);
        #1;
        expect_split(m_cnt, int'(mode), er, ec, ed);
        checks++;
        if (longint'(bit_addr) != m_cnt || longint'(row_addr) != er ||
            longint'(col_addr) != ec || dev_sel != (8'd1 << ed)) begin
            errors++;
            $display("FAIL %s R10: addr=%h row=%h col=%h dev=%b expected addr=%h row=%h col=%h dev=%b",
                     req, bit_addr, row_addr, col_addr, dev_sel,
                     m_cnt[24:0], er[11:0], ec[11:0], 8'd1 << ed);
        end
    endtask

    task automatic shift_in(input longint a, input string req);
        for (int i = 24; i >= 0; i--) begin
            tick(bit'((a >> i) & 1), 1'b1, 1'b0, 1'b1, req);
            tick(bit'((a >> i) & 1), 1'b0, 1'b0, 1'b1, req);
        end
    endtask

    task automatic load(input longint a, input string req);
        shift_in(a, req);
        tick(1'b0, 1'b0, 1'b1, 1'b1, req);
        tick(1'b0, 1'b0, 1'b0, 1'b1, req);
    endtask

    task automatic step(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick(1'b0, 1'b0, 1'b0, 1'b0, req);
            tick(1'b0, 1'b0, 1'b0, 1'b1, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        tick(0, 0, 0, 1, "R11 reset");
        tick(0, 0, 0, 1, "R11 reset");
        @(negedge clk); rst_n = 1'b1;
        tick(0, 0, 0, 1, "R11 idle");
        tick(0, 0, 1, 1, "R11 transfer after reset");
        tick(0, 0, 0, 1, "R11 transfer after reset");

        load(64'h3A5C3F, "R1 R6 load mode0");
        step(5, "R4 R6 step mode0");
        shift_in(64'h0123456, "R2 shift only");
        step(2, "R2 R4 step after shift");
        tick(0, 0, 1, 1, "R1 transfer of shifted value");
        tick(0, 0, 0, 1, "R1 transfer of shifted value");
        load(64'h7FFFFE, "R5 mode0 near end");
        step(3, "R5 R6 mode0 wrap");
        load(64'h1FFFFE, "R6 device boundary");
        step(3, "R6 R10 device boundary");

        @(negedge clk); mode = 2'b01;
        load(64'h1234567, "R7 mode1");
        step(3, "R7 step mode1");
        load(64'h1FFFFFE, "R5 mode1 near end");
        step(3, "R5 R7 mode1 wrap");

        @(negedge clk); mode = 2'b10;
        load(64'h3FFFFE, "R8 large to small");
        step(4, "R8 large to small");
        load(64'h4FFFFE, "R8 small to small");
        step(4, "R8 small to small");
        load(64'h6FFFFE, "R5 mode2 near end");
        step(3, "R5 R8 mode2 wrap");

        @(negedge clk); mode = 2'b11;
        load(64'hFFFFFE, "R9 part boundary");
        step(4, "R9 part boundary");
        load(64'h1FFFFFF, "R5 mode3 last");
        step(2, "R5 R9 mode3 wrap");

        load(64'h0ABCDE, "R3 setup");
        shift_in(64'h155555, "R3 setup second");
        tick(0, 1, 1, 1, "R3 shift and transfer same cycle");
        tick(0, 0, 0, 1, "R3 shift and transfer same cycle");
        tick(0, 0, 1, 0, "R3 transfer beats step");
        tick(0, 0, 0, 1, "R3 transfer beats step");
        step(2, "R4 after transfer");

        load(64'h1555555, "R11 setup");
        @(negedge clk); rst_n = 1'b0;
        tick(0, 0, 0, 1, "R11 mid-run reset");
        @(negedge clk); rst_n = 1'b1;
        tick(0, 0, 1, 1, "R11 register cleared");
        tick(0, 0, 0, 1, "R11 register cleared");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule